// File: doc/BRIEF.md
# Register-Mapped Serial Transceiver with Sticky Error Flags

This block is an 8-bit asynchronous serial transceiver attached to a simple single-cycle register bus with a 3-bit word address. Software writes a byte to the transmit register and the block shifts it out on the serial output. A frame is a low start bit, eight data bits least significant first, an optional parity bit and a high stop bit. Incoming frames on the serial input are oversampled at sixteen times the bit rate, checked at mid-bit, and placed in the receive register.

A 9-bit status word reports two transmit-side readiness flags, one receive-side readiness flag and five error conditions, plus a summary error bit. The error conditions are sticky: once set, they stay set until software writes anything to the status word, which clears all of them in one access and leaves the readiness flags alone. A control word holds one interrupt enable per status bit at the same bit position, and the single interrupt output is raised whenever any enabled status bit is set. An optional 16-bit divisor register sets the bit period.

Top module: `sbus_uart`

## Requirements
- R1: After reset, status (offset 2) reads 0x060 (only TRDY bit 6 and TMT bit 5 set), control (offset 3) reads 0, the divisor (offset 4) reads its default, the serial output is high and the interrupt output is low.
- R2: A write to offset 1 sends one frame on the serial output: a 0 start bit, data bits 0 to 7 in that order, an even parity bit equal to the XOR of the data (when parity is enabled, the default), and a 1 stop bit.
- R3: Status bit 6 (TRDY) is 1 while the transmit holding register is empty and bit 5 (TMT) is 1 when both the holding and the shift register are empty; a byte written while a frame is being shifted is held and sent right after it.
- R4: A write to offset 1 while TRDY is 0 sets status bit 4 (TOE) and the byte is discarded and never sent.
- R5: A completed received frame places its data in offset 0 (bits 7:0) and sets status bit 7 (RRDY); a read of offset 0 clears RRDY.
- R6: A frame that completes while RRDY is still 1 sets status bit 3 (ROE), and offset 0 then holds the newer byte.
- R7: A received parity bit that differs from the XOR of the received data sets status bit 0 (PE).
- R8: A stop bit sampled low sets status bit 1 (FE); when every sampled bit of the frame including the stop bit is low, status bit 2 (BRK) is set as well, and the receiver waits for the line to return high before looking for the next start bit.
- R9: Status bit 8 (E) is the OR of bits 4:0; bits 4:0 stay set until any write to offset 2, which clears bits 8 and 4:0 and leaves RRDY, TRDY and TMT unchanged.
- R10: Control (offset 3) stores and reads back 9 bits; the interrupt output is 1 exactly when some status bit and the control bit at the same position are both 1.
- R11: The divisor at offset 4 is readable and writable, and one bit lasts 16 x (divisor + 1) clock cycles on both transmit and receive.
- R12: Offsets 5 to 7 read 0, and a write to offset 0 changes nothing visible in status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 3 | Register word address |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access (read side effects) |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data for busAddr, combinational |
| txLine | output | 1 | Serial output, idles high |
| rxLine | input | 1 | Serial input, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The receive path is swept over all 256 byte values, which separates bit-order and bit-position faults from parity and flag faults, while the transmit path is tried with a spread of values including all-zero and all-one bytes so that the parity bit and the stop bit are told apart from data. Malformed frames are then injected one kind at a time: a wrong parity bit, a low stop bit, and a line held low for a whole frame, so that each error flag is seen to rise alone. Back-to-back writes and two unread frames check overrun on both sides, and a sequence that interleaves new frames with status writes separates stickiness from the clearing write. A second divisor value shows that the bit period follows the register rather than a constant.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;

  // Status and control bit positions (shared by the interrupt masking)
  localparam int ST_PE   = 0;
  localparam int ST_FE   = 1;
  localparam int ST_BRK  = 2;
  localparam int ST_ROE  = 3;
  localparam int ST_TOE  = 4;
  localparam int ST_TMT  = 5;
  localparam int ST_TRDY = 6;
  localparam int ST_RRDY = 7;
  localparam int ST_E    = 8;
  localparam int STAT_W  = 9;

  localparam logic [2:0] OFS_RXD  = 3'd0;
  localparam logic [2:0] OFS_TXD  = 3'd1;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_CTRL = 3'd3;
  localparam logic [2:0] OFS_DIV  = 3'd4;

  // Control -> datapath strobes
  typedef struct packed {
    logic       txLoad;
    logic [7:0] txByte;
  } ctlStrobe_t;

  // Datapath -> control events and levels
  typedef struct packed {
    logic rxDone;
    logic rxFe;
    logic rxPe;
    logic rxBrk;
    logic holdEmpty;
    logic shiftIdle;
  } dpEvent_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI
  } rxState_t;

endpackage

// File: rtl/uart_mm_txser.sv
module uart_mm_txser #(
  parameter bit PARITY_EN  = 1'b1,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] byteIn,
  output logic       txLine,
  output logic       holdEmpty,
  output logic       shiftIdle
);

  localparam int FRAME_W = 10 + (PARITY_EN ? 1 : 0);
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [7:0]         holdReg;
  logic               holdFull;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   bitsLeft;
  logic [3:0]         subCnt;
  logic               busy;
  logic               startShift;

  generate
    if (PARITY_EN) begin : g_par
      assign frame = {1'b1, (^holdReg) ^ PARITY_ODD, holdReg, 1'b0};
    end else begin : g_nopar
      assign frame = {1'b1, holdReg, 1'b0};
    end
  endgenerate

  assign startShift = holdFull && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (load) begin
      holdReg  <= byteIn;
      holdFull <= 1'b1;
    end else if (startShift) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitsLeft <= '0;
      subCnt   <= '0;
      busy     <= 1'b0;
    end else if (startShift) begin
      shiftReg <= frame;
      bitsLeft <= CNT_W'(FRAME_W);
      subCnt   <= '0;
      busy     <= 1'b1;
    end else if (busy && tick) begin
      if (subCnt == 4'd15) begin
        subCnt   <= '0;
        shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
        bitsLeft <= bitsLeft - 1'b1;
        if (bitsLeft == CNT_W'(1)) busy <= 1'b0;
      end else begin
        subCnt <= subCnt + 4'd1;
      end
    end
  end

  assign txLine    = busy ? shiftReg[0] : 1'b1;
  assign holdEmpty = !holdFull;
  assign shiftIdle = !busy;

endmodule

// File: rtl/uart_mm_rxser.sv
module uart_mm_rxser
  import uart_mm_pkg::*;
#(
  parameter bit PARITY_EN  = 1'b1,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxLine,
  output logic       rxDone,
  output logic       rxFe,
  output logic       rxPe,
  output logic       rxBrk,
  output logic [7:0] rxByte
);

  logic       rxMeta, rxSync;
  rxState_t   state;
  logic [3:0] subCnt;
  logic [2:0] bitIdx;
  logic [7:0] dataSh;
  logic       parSample;
  logic       allZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= RX_IDLE;
      subCnt    <= '0;
      bitIdx    <= '0;
      dataSh    <= '0;
      parSample <= 1'b0;
      allZero   <= 1'b0;
      rxDone    <= 1'b0;
      rxFe      <= 1'b0;
      rxPe      <= 1'b0;
      rxBrk     <= 1'b0;
      rxByte    <= '0;
    end else begin
      rxDone <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!rxSync) begin
              state  <= RX_START;
              subCnt <= '0;
            end
          end
          RX_START: begin
            if (subCnt == 4'd7) begin
              subCnt <= '0;
              if (!rxSync) begin
                state   <= RX_DATA;
                bitIdx  <= '0;
                allZero <= 1'b1;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              subCnt <= subCnt + 4'd1;
            end
          end
          RX_DATA: begin
            if (subCnt == 4'd15) begin
              subCnt  <= '0;
              dataSh  <= {rxSync, dataSh[7:1]};
              allZero <= allZero & !rxSync;
              bitIdx  <= bitIdx + 3'd1;
              if (bitIdx == 3'd7) state <= PARITY_EN ? RX_PAR : RX_STOP;
            end else begin
              subCnt <= subCnt + 4'd1;
            end
          end
          RX_PAR: begin
            if (subCnt == 4'd15) begin
              subCnt    <= '0;
              parSample <= rxSync;
              allZero   <= allZero & !rxSync;
              state     <= RX_STOP;
            end else begin
              subCnt <= subCnt + 4'd1;
            end
          end
          RX_STOP: begin
            if (subCnt == 4'd15) begin
              subCnt <= '0;
              rxDone <= 1'b1;
              rxByte <= dataSh;
              rxFe   <= !rxSync;
              rxBrk  <= !rxSync && allZero;
              rxPe   <= PARITY_EN && (parSample ^ (^dataSh) ^ PARITY_ODD);
              state  <= rxSync ? RX_IDLE : RX_WAITHI;
            end else begin
              subCnt <= subCnt + 4'd1;
            end
          end
          RX_WAITHI: begin
            if (rxSync) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_mm_dp.sv
module uart_mm_dp
  import uart_mm_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter bit PARITY_EN  = 1'b1,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rxLine,
  output logic             txLine,
  output dpEvent_t         dpEvt,
  output logic [7:0]       rxByte
);

  logic [DIV_W-1:0] baudCnt;
  logic             tick;
  logic             holdEmpty, shiftIdle;
  logic             rxDone, rxFe, rxPe, rxBrk;

  // Oversample tick: one pulse every divisor+1 clocks
  assign tick = (baudCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     baudCnt <= '0;
    else if (tick) baudCnt <= divisor;
    else           baudCnt <= baudCnt - 1'b1;
  end

  uart_mm_txser #(.PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_tx (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .load      (strobe.txLoad),
    .byteIn    (strobe.txByte),
    .txLine    (txLine),
    .holdEmpty (holdEmpty),
    .shiftIdle (shiftIdle)
  );

  uart_mm_rxser #(.PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_rx (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .rxLine (rxLine),
    .rxDone (rxDone),
    .rxFe   (rxFe),
    .rxPe   (rxPe),
    .rxBrk  (rxBrk),
    .rxByte (rxByte)
  );

  assign dpEvt.rxDone    = rxDone;
  assign dpEvt.rxFe      = rxFe;
  assign dpEvt.rxPe      = rxPe;
  assign dpEvt.rxBrk     = rxBrk;
  assign dpEvt.holdEmpty = holdEmpty;
  assign dpEvt.shiftIdle = shiftIdle;

endmodule

// File: rtl/uart_mm_ctrl.sv
module uart_mm_ctrl
  import uart_mm_pkg::*;
#(
  parameter int               DIV_W       = 16,
  parameter logic [DIV_W-1:0] DEFAULT_DIV = '0,
  parameter bit               HAS_DIV_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [15:0]       busWData,
  output logic [15:0]       busRData,
  input  dpEvent_t          dpEvt,
  input  logic [7:0]        rxByte,
  output ctlStrobe_t        strobe,
  output logic [DIV_W-1:0]  divisor,
  output logic [STAT_W-1:0] statusVec,
  output logic [STAT_W-1:0] ctrlVec
);

  logic wrTx, wrStat, wrCtrl, wrDiv, rdRx;
  logic rrdy, toe, roe, brk, fe, pe;
  logic [STAT_W-1:0] ctrlReg;

  assign wrTx   = busWr && (busAddr == OFS_TXD);
  assign wrStat = busWr && (busAddr == OFS_STAT);
  assign wrCtrl = busWr && (busAddr == OFS_CTRL);
  assign wrDiv  = busWr && (busAddr == OFS_DIV);
  assign rdRx   = busRd && (busAddr == OFS_RXD);

  assign strobe.txLoad = wrTx && dpEvt.holdEmpty;
  assign strobe.txByte = busWData[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrdy <= 1'b0;
      toe  <= 1'b0;
      roe  <= 1'b0;
      brk  <= 1'b0;
      fe   <= 1'b0;
      pe   <= 1'b0;
    end else begin
      if (dpEvt.rxDone) rrdy <= 1'b1;
      else if (rdRx)    rrdy <= 1'b0;
      // sticky errors: a new event wins over the clearing write
      toe <= (toe & !wrStat) | (wrTx && !dpEvt.holdEmpty);
      roe <= (roe & !wrStat) | (dpEvt.rxDone && rrdy && !rdRx);
      brk <= (brk & !wrStat) | (dpEvt.rxDone && dpEvt.rxBrk);
      fe  <= (fe  & !wrStat) | (dpEvt.rxDone && dpEvt.rxFe);
      pe  <= (pe  & !wrStat) | (dpEvt.rxDone && dpEvt.rxPe);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlReg <= '0;
    else if (wrCtrl) ctrlReg <= busWData[STAT_W-1:0];
  end

  generate
    if (HAS_DIV_REG) begin : g_div
      logic [DIV_W-1:0] divReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      divReg <= DEFAULT_DIV;
        else if (wrDiv) divReg <= busWData[DIV_W-1:0];
      end
      assign divisor = divReg;
    end else begin : g_fixdiv
      assign divisor = DEFAULT_DIV;
    end
  endgenerate

  always_comb begin
    statusVec          = '0;
    statusVec[ST_PE]   = pe;
    statusVec[ST_FE]   = fe;
    statusVec[ST_BRK]  = brk;
    statusVec[ST_ROE]  = roe;
    statusVec[ST_TOE]  = toe;
    statusVec[ST_TMT]  = dpEvt.holdEmpty && dpEvt.shiftIdle;
    statusVec[ST_TRDY] = dpEvt.holdEmpty;
    statusVec[ST_RRDY] = rrdy;
    statusVec[ST_E]    = pe | fe | brk | roe | toe;
  end

  assign ctrlVec = ctrlReg;

  always_comb begin
    case (busAddr)
      OFS_RXD:  busRData = {8'h00, rxByte};
      OFS_STAT: busRData = 16'(statusVec);
      OFS_CTRL: busRData = 16'(ctrlReg);
      OFS_DIV:  busRData = 16'(divisor);
      default:  busRData = 16'h0000;
    endcase
  end

endmodule

// File: rtl/sbus_uart.sv
module sbus_uart
  import uart_mm_pkg::*;
#(
  parameter int               DIV_W       = 16,
  parameter logic [DIV_W-1:0] DEFAULT_DIV = '0,
  parameter bit               HAS_DIV_REG = 1'b1,
  parameter bit               PARITY_EN   = 1'b1,
  parameter bit               PARITY_ODD  = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [15:0] busWData,
  output logic [15:0] busRData,
  output logic        txLine,
  input  logic        rxLine,
  output logic        irq
);

  ctlStrobe_t        strobe;
  dpEvent_t          dpEvt;
  logic [DIV_W-1:0]  divisor;
  logic [7:0]        rxByte;
  logic [STAT_W-1:0] statusVec;
  logic [STAT_W-1:0] ctrlVec;

  uart_mm_ctrl #(
    .DIV_W(DIV_W), .DEFAULT_DIV(DEFAULT_DIV), .HAS_DIV_REG(HAS_DIV_REG)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .busWData  (busWData),
    .busRData  (busRData),
    .dpEvt     (dpEvt),
    .rxByte    (rxByte),
    .strobe    (strobe),
    .divisor   (divisor),
    .statusVec (statusVec),
    .ctrlVec   (ctrlVec)
  );

  uart_mm_dp #(
    .DIV_W(DIV_W), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .divisor (divisor),
    .rxLine  (rxLine),
    .txLine  (txLine),
    .dpEvt   (dpEvt),
    .rxByte  (rxByte)
  );

  assign irq = |(statusVec & ctrlVec);

endmodule

// File: rtl/sbus_uart_chk.sv
module sbus_uart_chk
  import uart_mm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic              txLine,
  input logic              irq,
  input logic              rxDone,
  input logic [STAT_W-1:0] statusVec,
  input logic [STAT_W-1:0] ctrlVec
);

  // R4: transmit write with a full holding register flags overrun
  a_r4_toe_sets: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_TXD && !statusVec[ST_TRDY]) |=> statusVec[ST_TOE]);

  // R3: with nothing left to send, the line rests high
  a_r3_tmt_line_idle: assert property (@(posedge clk) disable iff (!rstN)
    statusVec[ST_TMT] |-> txLine);

  // R5: reading received data drops the ready flag
  a_r5_read_clears_rrdy: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == OFS_RXD && !rxDone) |=> !statusVec[ST_RRDY]);

  // R6: a frame landing on unread data flags overrun
  a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && statusVec[ST_RRDY] && !(busRd && busAddr == OFS_RXD)) |=> statusVec[ST_ROE]);

  // R9: framing error stays until a status write
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec[ST_FE] && !(busWr && busAddr == OFS_STAT)) |=> statusVec[ST_FE]);

  // R9: a status write with no concurrent event clears every error bit
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_STAT && !rxDone) |=> (statusVec[4:0] == 5'd0 && !statusVec[ST_E]));

  // R10: no enables, no interrupt
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlVec == '0) |-> !irq);

endmodule

bind sbus_uart sbus_uart_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busRd     (busRd),
  .txLine    (txLine),
  .irq       (irq),
  .rxDone    (dpEvt.rxDone),
  .statusVec (statusVec),
  .ctrlVec   (ctrlVec)
);

// File: tb/sbus_uart_bench.sv
`timescale 1ns/1ps
module sbus_uart_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  busAddr;
  logic        busWr, busRd;
  logic [15:0] busWData;
  logic [15:0] busRData;
  logic        txLine;
  logic        rxLine;
  logic        irq;

  int nRun  = 0;
  int nFail = 0;
  int bitP  = 16;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sbus_uart u_sbus_uart (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWData(busWData), .busRData(busRData), .txLine(txLine), .rxLine(rxLine), .irq(irq)
  );

  localparam logic [31:0] S_IDLE = 32'h060;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b, input bit badPar, input bit stopVal);
    @(negedge clk);
    rxLine = 1'b0; repeat (bitP) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i]; repeat (bitP) @(negedge clk);
    end
    rxLine = (^b) ^ badPar; repeat (bitP) @(negedge clk);
    rxLine = stopVal; repeat (bitP) @(negedge clk);
    rxLine = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic grabTx(output logic [7:0] d, output logic p, output logic s);
    int waitN = 0;
    d = 'x; p = 1'bx; s = 1'bx;
    while (txLine !== 1'b0 && waitN < 40 * bitP) begin
      @(negedge clk); waitN++;
    end
    if (txLine === 1'b0) begin
      repeat (bitP / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (bitP) @(negedge clk); d[i] = txLine;
      end
      repeat (bitP) @(negedge clk); p = txLine;
      repeat (bitP) @(negedge clk); s = txLine;
    end
  endtask

  task automatic checkTx(input string tag, input logic [7:0] v);
    logic [7:0] d; logic p, s;
    grabTx(d, p, s);
    chk({tag, " data"}, 32'(d), 32'(v));
    chk({tag, " parity"}, 32'(p), 32'(^v));
    chk({tag, " stop"}, 32'(s), 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int lows;
    busAddr = '0; busWr = 1'b0; busRd = 1'b0; busWData = '0; rxLine = 1'b1;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 txLine", 32'(txLine), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    busRead(3'd2, rd); chk("R1 status", 32'(rd), S_IDLE);
    busRead(3'd3, rd); chk("R1 control", 32'(rd), 32'd0);
    busRead(3'd4, rd); chk("R1 divisor", 32'(rd), 32'd0);

    // R12 unused offsets and write to offset 0
    for (int a = 5; a < 8; a++) begin
      busRead(3'(a), rd); chk("R12 unused offset", 32'(rd), 32'd0);
    end
    busWrite(3'd0, 16'h00FF);
    busRead(3'd2, rd); chk("R12 write rxdata ignored", 32'(rd), S_IDLE);

    // R2 transmit sweep
    for (int k = 0; k < 16; k++) begin
      logic [7:0] v;
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 73 + 5) & 255);
      busWrite(3'd1, {8'h00, v});
      checkTx("R2 tx", v);
      repeat (bitP) @(negedge clk);
      busRead(3'd2, rd); chk("R3 idle after frame", 32'(rd), S_IDLE);
    end

    // R3 second byte held while shifting
    busWrite(3'd1, 16'h00A3);
    repeat (3) @(negedge clk);
    busWrite(3'd1, 16'h005C);
    busRead(3'd2, rd); chk("R3 TRDY/TMT busy", 32'(rd) & 32'h060, 32'd0);
    checkTx("R3 first", 8'hA3);
    checkTx("R3 held", 8'h5C);
    repeat (bitP) @(negedge clk);
    busRead(3'd2, rd); chk("R3 idle", 32'(rd), S_IDLE);

    // R4 back-to-back writes: second dropped
    @(negedge clk);
    busAddr = 3'd1; busWData = 16'h0081; busWr = 1'b1;
    @(negedge clk);
    busWData = 16'h007E;
    @(negedge clk);
    busWr = 1'b0;
    checkTx("R4 first kept", 8'h81);
    repeat (bitP) @(negedge clk);
    busRead(3'd2, rd); chk("R4 TOE and E", 32'(rd), 32'h170);
    lows = 0;
    for (int i = 0; i < 12 * bitP; i++) begin
      @(negedge clk); if (txLine !== 1'b1) lows++;
    end
    chk("R4 dropped byte not sent", 32'(lows), 32'd0);

    // R9 status write clears errors
    busWrite(3'd2, 16'h0000);
    busRead(3'd2, rd); chk("R9 clear TOE", 32'(rd), S_IDLE);

    // R5 receive sweep over all byte values
    for (int v = 0; v < 256; v++) begin
      sendRx(8'(v), 1'b0, 1'b1);
      busRead(3'd2, rd); chk("R5 RRDY set", 32'(rd), 32'h0E0);
      busRead(3'd0, rd); chk("R5 data", 32'(rd), 32'(v));
      busRead(3'd2, rd); chk("R5 RRDY cleared", 32'(rd), S_IDLE);
    end

    // R6 receive overrun
    sendRx(8'h3C, 1'b0, 1'b1);
    sendRx(8'hC3, 1'b0, 1'b1);
    busRead(3'd2, rd); chk("R6 ROE", 32'(rd), 32'h1E8);
    busRead(3'd0, rd); chk("R6 newest data", 32'(rd), 32'h0C3);
    busRead(3'd2, rd); chk("R6 ROE sticky after read", 32'(rd), 32'h168);
    busWrite(3'd2, 16'h0000);
    busRead(3'd2, rd); chk("R9 clear ROE", 32'(rd), S_IDLE);

    // R7 parity error, R10 interrupt masking
    sendRx(8'h5A, 1'b1, 1'b1);
    busRead(3'd2, rd); chk("R7 PE", 32'(rd), 32'h1E1);
    chk("R10 irq off with no enables", 32'(irq), 32'd0);
    busWrite(3'd3, 16'h0001);
    chk("R10 irq on iPE", 32'(irq), 32'd1);
    busRead(3'd3, rd); chk("R10 control readback", 32'(rd), 32'h001);
    busWrite(3'd3, 16'h0002);
    chk("R10 irq off iFE", 32'(irq), 32'd0);
    busWrite(3'd3, 16'h0180);
    chk("R10 irq on iRRDY", 32'(irq), 32'd1);
    busRead(3'd0, rd); chk("R7 data", 32'(rd), 32'h05A);
    // R9 stickiness across a clean frame, clear keeps RRDY
    sendRx(8'h11, 1'b0, 1'b1);
    busRead(3'd2, rd); chk("R9 PE sticky", 32'(rd), 32'h1E1);
    busWrite(3'd2, 16'h01FF);
    busRead(3'd2, rd); chk("R9 clear keeps RRDY", 32'(rd), 32'h0E0);
    busWrite(3'd3, 16'h011F);
    chk("R10 irq off after clear", 32'(irq), 32'd0);
    busRead(3'd0, rd); chk("R9 data", 32'(rd), 32'h011);
    busWrite(3'd3, 16'h0000);

    // R8 framing error
    sendRx(8'hA5, 1'b0, 1'b0);
    busRead(3'd2, rd); chk("R8 FE", 32'(rd), 32'h1E2);
    busRead(3'd0, rd); chk("R8 FE data", 32'(rd), 32'h0A5);
    busWrite(3'd2, 16'h0000);

    // R8 break then recovery
    @(negedge clk);
    rxLine = 1'b0; repeat (11 * bitP) @(negedge clk);
    rxLine = 1'b1; repeat (2 * bitP) @(negedge clk);
    busRead(3'd2, rd); chk("R8 BRK", 32'(rd), 32'h1E6);
    busRead(3'd0, rd); chk("R8 BRK data", 32'(rd), 32'h000);
    busWrite(3'd2, 16'h0000);
    sendRx(8'h77, 1'b0, 1'b1);
    busRead(3'd2, rd); chk("R8 recovered status", 32'(rd), 32'h0E0);
    busRead(3'd0, rd); chk("R8 recovered data", 32'(rd), 32'h077);

    // R11 divisor
    busWrite(3'd4, 16'h0001);
    busRead(3'd4, rd); chk("R11 divisor readback", 32'(rd), 32'h001);
    bitP = 32;
    busWrite(3'd1, 16'h00C6);
    checkTx("R11 tx slow", 8'hC6);
    repeat (bitP) @(negedge clk);
    sendRx(8'h39, 1'b0, 1'b1);
    busRead(3'd2, rd); chk("R11 rx slow status", 32'(rd), 32'h0E0);
    busRead(3'd0, rd); chk("R11 rx slow data", 32'(rd), 32'h039);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule